// File: doc/BRIEF.md
# MMIO Window to Partition Decoder

This block holds a table of address windows and, for every incoming memory-mapped request address, reports which partition number (PE) owns it. Each window describes its range as a base and a mask: an address belongs to the window when the address ANDed with the mask equals the base. The window size and alignment are therefore always a power of two. The PE comes either from a single programmed value or from the position of the address inside the window. In the positional case the window is cut into equal segments and the segment index selects or offsets the PE.

Software programs a window through a write port. It sets the base, the mask, the mapping mode, the PE value and, for the per-segment mode, one PE register per segment. It then issues an enable command. Before the window goes live, the enable command checks that the programmed mode fits the range. Any window that fails the check stays off, and the reason is kept in a status output. An enabled window is frozen. To reprogram it, software disables it first.

A lookup strobe with an address gives a registered result one clock later. The result holds hit or miss, the index of the matching window and the PE.

Top module: `mmio_pe_decoder`

## Requirements
- R1: A window matches an address only while it is enabled and (address AND mask) equals its base; a disabled or rejected window never produces a hit.
- R2: In equal-segment mode (`MD_EQUAL`) the window is split into 256 segments and the PE equals the index of the segment holding the address, i.e. the top 8 bits of the offset within the window.
- R3: In single mode (`MD_SINGLE`) every address of the window yields the programmed PE value.
- R4: Enabling a single-mode window whose mask or base has any of the low 25 bits set (size or alignment below 32 MB) is refused with status `RJ_ALIGN`.
- R5: In per-segment mode (`MD_INDIV`) the window has 8 segments, and each segment returns the value of its own PE register (written with `CF_SEGPE`, segment number on `cfg_seg`).
- R6: In offset mode (`MD_OFFSET`) the segment count is 8, 64 or 128 for count codes 0, 1 or 2 (mode write data bits [3:2]), and segment n yields PE base+n. A base PE that is not a multiple of the count is refused with `RJ_BASEPE`. Count code 3 is refused with `RJ_COUNT`.
- R7: The enable command carries a split flag in data bit 0. The flag must be 0 for single mode and 1 for all segmented modes, otherwise the enable is refused with `RJ_SPLIT`. This check comes before all others.
- R8: Writes of base, mask, mode, PE or segment PE to an enabled window leave it unchanged and set the sticky `st_lock_err` output.
- R9: When several enabled windows match, the lowest-numbered one is reported.
- R10: A lookup that matches no window reports `res_hit`=0, `res_win`=0 and `res_pe`=0.
- R11: The result appears with `res_valid`=1 exactly one clock after `lk_valid`. In a cycle after no strobe, `res_valid` and the other result outputs are 0.
- R12: A segmented window smaller than its segment count (fewer address bits below the mask than segment bits) is refused with `RJ_SMALL`. Every enable attempt updates `st_reason`, and a successful enable writes `RJ_NONE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 4 | Window addressed by the write |
| cfg_sel | input | 3 | Write command (`cfg_sel_e`) |
| cfg_seg | input | 3 | Segment number for a segment PE write |
| cfg_data | input | 36 | Write data (base, mask, mode/count, PE, split flag) |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 36 | Lookup address |
| res_valid | output | 1 | Registered lookup result valid |
| res_hit | output | 1 | A window matched |
| res_win | output | 4 | Index of the matching window |
| res_pe | output | 8 | Partition number |
| st_reason | output | 3 | Outcome of the last enable attempt (`reject_e`) |
| st_lock_err | output | 1 | Sticky flag: a write hit an enabled window |

## Verification
The hardest situation to reach is an overlap, where two live windows claim the same address and only the index order decides which one answers. From the ports this needs a large single-mode window placed over a smaller segmented one, and the result has to be seen both before and after the large window is switched off. The bench programs exactly that overlap with directed writes. It also forces each enable rejection with a configuration that breaks only one rule. After that, random addresses are aimed inside each live window, with random misses mixed in, and every result is compared to a bench model of the programmed table.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
    localparam int ADDR_W          = 36;
    localparam int NUM_WIN         = 16;
    localparam int PE_W            = 8;
    localparam int IND_SEGS        = 8;
    localparam int SINGLE_ALIGN_LG = 25;
    localparam int LG_W            = $clog2(ADDR_W + 1);
    localparam int WIN_W           = $clog2(NUM_WIN);
    localparam int IND_W           = $clog2(IND_SEGS);

    typedef enum logic [1:0] {MD_EQUAL, MD_SINGLE, MD_INDIV, MD_OFFSET} map_mode_e;
    typedef enum logic [2:0] {CF_BASE, CF_MASK, CF_MODE, CF_PE, CF_SEGPE,
                              CF_ENABLE, CF_DISABLE} cfg_sel_e;
    typedef enum logic [2:0] {RJ_NONE, RJ_SPLIT, RJ_ALIGN, RJ_BASEPE,
                              RJ_COUNT, RJ_SMALL} reject_e;

    typedef struct packed {
        logic              en;
        map_mode_e         mode;
        logic [1:0]        ocnt;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic [PE_W-1:0]   pe;
        logic [LG_W-1:0]   lg;
    } win_t;

    // number of zero bits below the lowest set mask bit = log2 of window size
    function automatic logic [LG_W-1:0] low_zeros(input logic [ADDR_W-1:0] m);
        logic [LG_W-1:0] n;
        logic stop;
        n = '0;
        stop = 1'b0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (!stop) begin
                if (m[i]) stop = 1'b1;
                else      n = n + 1'b1;
            end
        end
        return n;
    endfunction

    // log2 of the segment count used by a mode
    function automatic logic [LG_W-1:0] seg_lg(input map_mode_e md, input logic [1:0] oc);
        case (md)
            MD_EQUAL:  return LG_W'(PE_W);
            MD_INDIV:  return LG_W'(IND_W);
            MD_OFFSET: return (oc == 2'd0) ? LG_W'(3) : (oc == 2'd1) ? LG_W'(6) : LG_W'(7);
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/mpd_win_table.sv
module mpd_win_table
    import mpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WIN_W-1:0]  cfg_win,
    input  cfg_sel_e          cfg_sel,
    input  logic [IND_W-1:0]  cfg_seg,
    input  logic [ADDR_W-1:0] cfg_data,
    output win_t              wins [NUM_WIN],
    output logic [PE_W-1:0]   segpe [NUM_WIN][IND_SEGS],
    output reject_e           st_reason,
    output logic              st_lock_err
);
    win_t            wins_q [NUM_WIN];
    logic [PE_W-1:0] segpe_q [NUM_WIN][IND_SEGS];
    logic [LG_W-1:0] sel_lg, sel_sl;
    logic [PE_W-1:0] pe_lowmask;
    reject_e         verdict;

    assign wins  = wins_q;
    assign segpe = segpe_q;

    always_comb begin
        sel_lg     = low_zeros(wins_q[cfg_win].mask);
        sel_sl     = seg_lg(wins_q[cfg_win].mode, wins_q[cfg_win].ocnt);
        pe_lowmask = PE_W'((32'd1 << sel_sl) - 32'd1);
        if (cfg_data[0] != (wins_q[cfg_win].mode != MD_SINGLE))
            verdict = RJ_SPLIT;
        else if (wins_q[cfg_win].mode == MD_OFFSET && wins_q[cfg_win].ocnt == 2'd3)
            verdict = RJ_COUNT;
        else if (sel_lg < sel_sl)
            verdict = RJ_SMALL;
        else if (wins_q[cfg_win].mode == MD_SINGLE &&
                 (sel_lg < LG_W'(SINGLE_ALIGN_LG) ||
                  |wins_q[cfg_win].base[SINGLE_ALIGN_LG-1:0]))
            verdict = RJ_ALIGN;
        else if (wins_q[cfg_win].mode == MD_OFFSET && |(wins_q[cfg_win].pe & pe_lowmask))
            verdict = RJ_BASEPE;
        else
            verdict = RJ_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                wins_q[w] <= '0;
                for (int s = 0; s < IND_SEGS; s++) segpe_q[w][s] <= '0;
            end
            st_reason   <= RJ_NONE;
            st_lock_err <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                CF_ENABLE: begin
                    st_reason <= verdict;
                    if (verdict == RJ_NONE) begin
                        wins_q[cfg_win].en <= 1'b1;
                        wins_q[cfg_win].lg <= sel_lg;
                    end
                end
                CF_DISABLE: wins_q[cfg_win].en <= 1'b0;
                default: begin
                    if (wins_q[cfg_win].en) begin
                        st_lock_err <= 1'b1;
                    end else begin
                        case (cfg_sel)
                            CF_BASE:  wins_q[cfg_win].base <= cfg_data;
                            CF_MASK:  wins_q[cfg_win].mask <= cfg_data;
                            CF_MODE: begin
                                wins_q[cfg_win].mode <= map_mode_e'(cfg_data[1:0]);
                                wins_q[cfg_win].ocnt <= cfg_data[3:2];
                            end
                            CF_PE:    wins_q[cfg_win].pe <= cfg_data[PE_W-1:0];
                            CF_SEGPE: segpe_q[cfg_win][cfg_seg] <= cfg_data[PE_W-1:0];
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_chk
        // R8
        frozen_range_chk: assert property (@(posedge clk) disable iff (rst)
            $past(wins_q[g].en) |-> $stable(wins_q[g].base) && $stable(wins_q[g].mask)
                                    && $stable(wins_q[g].pe));
        // R4
        single_align_chk: assert property (@(posedge clk) disable iff (rst)
            (wins_q[g].en && wins_q[g].mode == MD_SINGLE) |->
                (wins_q[g].mask[SINGLE_ALIGN_LG-1:0] == '0 &&
                 wins_q[g].base[SINGLE_ALIGN_LG-1:0] == '0));
        // R6
        offset_base_chk: assert property (@(posedge clk) disable iff (rst)
            (wins_q[g].en && wins_q[g].mode == MD_OFFSET) |->
                (wins_q[g].ocnt == 2'd0 ? wins_q[g].pe[2:0] == 3'd0 :
                 wins_q[g].ocnt == 2'd1 ? wins_q[g].pe[5:0] == 6'd0 :
                 wins_q[g].ocnt == 2'd2 ? wins_q[g].pe[6:0] == 7'd0 : 1'b0));
    end
endmodule

// File: rtl/mpd_win_decode.sv
module mpd_win_decode
    import mpd_pkg::*;
(
    input  win_t              w,
    input  logic [PE_W-1:0]   segpe_row [IND_SEGS],
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [PE_W-1:0]   pe
);
    logic [ADDR_W-1:0] off;
    logic [LG_W-1:0]   sh;
    logic [PE_W-1:0]   seg;

    always_comb begin
        hit = w.en && ((addr & w.mask) == w.base);
        off = addr & ~w.mask;
        sh  = w.lg - seg_lg(w.mode, w.ocnt);
        seg = PE_W'(off >> sh);
        case (w.mode)
            MD_EQUAL:  pe = seg;
            MD_SINGLE: pe = w.pe;
            MD_INDIV:  pe = segpe_row[seg[IND_W-1:0]];
            default:   pe = w.pe + seg;
        endcase
    end
endmodule

// File: rtl/mpd_pick.sv
module mpd_pick
    import mpd_pkg::*;
(
    input  logic [NUM_WIN-1:0] hits,
    input  logic [PE_W-1:0]    pes [NUM_WIN],
    output logic               any,
    output logic [WIN_W-1:0]   idx,
    output logic [PE_W-1:0]    pe
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        pe  = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = WIN_W'(i);
                pe  = pes[i];
            end
        end
    end
endmodule

// File: rtl/mmio_pe_decoder.sv
module mmio_pe_decoder
    import mpd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [WIN_W-1:0]     cfg_win,
    input  logic [2:0]           cfg_sel,
    input  logic [IND_W-1:0]     cfg_seg,
    input  logic [ADDR_W-1:0]    cfg_data,
    input  logic                 lk_valid,
    input  logic [ADDR_W-1:0]    lk_addr,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic [WIN_W-1:0]     res_win,
    output logic [PE_W-1:0]      res_pe,
    output logic [2:0]           st_reason,
    output logic                 st_lock_err
);
    win_t               wins [NUM_WIN];
    logic [PE_W-1:0]    segpe [NUM_WIN][IND_SEGS];
    logic [NUM_WIN-1:0] hits;
    logic [PE_W-1:0]    pes [NUM_WIN];
    reject_e            reason;
    logic               any;
    logic [WIN_W-1:0]   idx;
    logic [PE_W-1:0]    pe_sel;

    mpd_win_table u_table (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel_e'(cfg_sel)), .cfg_seg(cfg_seg), .cfg_data(cfg_data),
        .wins(wins), .segpe(segpe), .st_reason(reason), .st_lock_err(st_lock_err)
    );
    assign st_reason = reason;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        mpd_win_decode u_dec (
            .w(wins[g]), .segpe_row(segpe[g]), .addr(lk_addr),
            .hit(hits[g]), .pe(pes[g])
        );
    end

    mpd_pick u_pick (.hits(hits), .pes(pes), .any(any), .idx(idx), .pe(pe_sel));

    always_ff @(posedge clk) begin
        if (rst || !lk_valid) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_win   <= '0;
            res_pe    <= '0;
        end else begin
            res_valid <= 1'b1;
            res_hit   <= any;
            res_win   <= any ? idx : '0;
            res_pe    <= any ? pe_sel : '0;
        end
    end

    // R11
    strobe_to_result_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);
    // R11
    idle_result_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid && !res_hit);
    // R10
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_pe == '0 && res_win == '0));
endmodule

// File: tb/mmio_pe_decoder_test.sv
`timescale 1ns/1ps
module mmio_pe_decoder_test;
    import mpd_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [WIN_W-1:0]  cfg_win = '0;
    logic [2:0]        cfg_sel = '0;
    logic [IND_W-1:0]  cfg_seg = '0;
    logic [ADDR_W-1:0] cfg_data = '0;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              res_valid, res_hit, st_lock_err;
    logic [WIN_W-1:0]  res_win;
    logic [PE_W-1:0]   res_pe;
    logic [2:0]        st_reason;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model of the programmed table
    logic [ADDR_W-1:0] m_base [NUM_WIN];
    logic [ADDR_W-1:0] m_mask [NUM_WIN];
    int                m_mode [NUM_WIN];
    int                m_cnt  [NUM_WIN];
    int                m_pe   [NUM_WIN];
    bit                m_en   [NUM_WIN];
    int                m_seg  [NUM_WIN][IND_SEGS];

    mmio_pe_decoder uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel),
        .cfg_seg(cfg_seg), .cfg_data(cfg_data), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_win(res_win), .res_pe(res_pe),
        .st_reason(st_reason), .st_lock_err(st_lock_err)
    );

    always #2.5 clk = ~clk;

    function automatic logic [ADDR_W-1:0] mk(input int lg);
        return ~((ADDR_W'(1) << lg) - ADDR_W'(1));
    endfunction

    function automatic int size_lg(input logic [ADDR_W-1:0] m);
        for (int i = 0; i < ADDR_W; i++) if (m[i]) return i;
        return ADDR_W;
    endfunction

    // expected {hit, win, pe} from the requirements
    function automatic void model(input logic [ADDR_W-1:0] a, output bit h,
                                  output int w, output int p);
        h = 0; w = 0; p = 0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (!h && m_en[i] && ((a & m_mask[i]) == m_base[i])) begin
                int lg, cnt_lg, s;
                lg = size_lg(m_mask[i]);
                cnt_lg = (m_mode[i] == MD_EQUAL) ? 8 : (m_mode[i] == MD_INDIV) ? 3 :
                         (m_cnt[i] == 0) ? 3 : (m_cnt[i] == 1) ? 6 : 7;
                s = int'((a & ~m_mask[i]) >> (lg - cnt_lg));
                h = 1; w = i;
                case (m_mode[i])
                    MD_EQUAL:  p = s;
                    MD_SINGLE: p = m_pe[i];
                    MD_INDIV:  p = m_seg[i][s];
                    default:   p = m_pe[i] + s;
                endcase
            end
        end
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int w, input cfg_sel_e s, input longint d, input int sg = 0);
        @(negedge clk);
        cfg_we = 1; cfg_win = WIN_W'(w); cfg_sel = s; cfg_data = ADDR_W'(d);
        cfg_seg = IND_W'(sg);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic look(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        lk_valid = 1; lk_addr = a;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic look_chk(input string req, input logic [ADDR_W-1:0] a);
        bit h; int w, p;
        model(a, h, w, p);
        look(a);
        chk({req, " valid"}, res_valid, 1);
        chk({req, " hit"}, res_hit, h);
        chk({req, " win"}, res_win, w);
        chk({req, " pe"}, res_pe, p);
    endtask

    task automatic prog(input int w, input logic [ADDR_W-1:0] b, input int lg,
                        input int md, input int cnt, input int pe);
        cfg(w, CF_BASE, b);
        cfg(w, CF_MASK, mk(lg));
        cfg(w, CF_MODE, (cnt << 2) | md);
        cfg(w, CF_PE, pe);
    endtask

    task automatic accept(input int w, input logic [ADDR_W-1:0] b, input int lg,
                          input int md, input int cnt, input int pe);
        m_base[w] = b; m_mask[w] = mk(lg); m_mode[w] = md; m_cnt[w] = cnt; m_pe[w] = pe;
        m_en[w] = 1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NUM_WIN; i++) begin
            m_en[i] = 0; m_base[i] = '0; m_mask[i] = '0; m_mode[i] = 0; m_cnt[i] = 0; m_pe[i] = 0;
            for (int s = 0; s < IND_SEGS; s++) m_seg[i][s] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        // reset state (R11, R12, R8)
        chk("R11 reset valid", res_valid, 0);
        chk("R12 reset reason", st_reason, RJ_NONE);
        chk("R8 reset lock", st_lock_err, 0);

        // R2: equal segments, 1 MB window
        prog(3, 36'h1_0000_0000, 20, MD_EQUAL, 0, 0);
        look_chk("R1 before enable", 36'h1_0000_0000);
        cfg(3, CF_ENABLE, 1);
        chk("R12 enable ok", st_reason, RJ_NONE);
        accept(3, 36'h1_0000_0000, 20, MD_EQUAL, 0, 0);
        look_chk("R2 seg 0", 36'h1_0000_0000);
        look_chk("R2 seg AB", 36'h1_000A_B123);
        look_chk("R2 seg FF", 36'h1_000F_FFFF);
        look_chk("R10 just outside", 36'h1_0010_0000);

        // R3: single 32 MB window
        prog(1, 36'h2_0000_0000, 25, MD_SINGLE, 0, 8'h5A);
        cfg(1, CF_ENABLE, 0);
        chk("R3 enable ok", st_reason, RJ_NONE);
        accept(1, 36'h2_0000_0000, 25, MD_SINGLE, 0, 8'h5A);
        look_chk("R3 low", 36'h2_0000_0000);
        look_chk("R3 high", 36'h2_01FF_FFFF);

        // R4: single window too small
        prog(2, 36'h5_0000_0000, 20, MD_SINGLE, 0, 8'h11);
        cfg(2, CF_ENABLE, 0);
        chk("R4 reason", st_reason, RJ_ALIGN);
        look_chk("R4 R1 rejected no hit", 36'h5_0000_0010);

        // R7: split flag mismatch
        prog(4, 36'h6_0000_0000, 25, MD_SINGLE, 0, 8'h22);
        cfg(4, CF_ENABLE, 1);
        chk("R7 reason", st_reason, RJ_SPLIT);
        look_chk("R7 stays off", 36'h6_0000_0000);

        // R5: per-segment, 64 KB window, 8 KB segments
        prog(5, 36'h3_0000_0000, 16, MD_INDIV, 0, 0);
        for (int s = 0; s < IND_SEGS; s++) begin
            cfg(5, CF_SEGPE, 8'h10 + 3 * s, s);
            m_seg[5][s] = 8'h10 + 3 * s;
        end
        cfg(5, CF_ENABLE, 1);
        chk("R5 enable ok", st_reason, RJ_NONE);
        accept(5, 36'h3_0000_0000, 16, MD_INDIV, 0, 0);
        for (int s = 0; s < IND_SEGS; s++) look_chk("R5 segment", 36'h3_0000_0000 + s * 36'h2000 + 36'h7);

        // R6: offset mode, 64 segments, base PE 64
        prog(6, 36'h4_0000_0000, 16, MD_OFFSET, 1, 64);
        cfg(6, CF_ENABLE, 1);
        chk("R6 enable ok", st_reason, RJ_NONE);
        accept(6, 36'h4_0000_0000, 16, MD_OFFSET, 1, 64);
        look_chk("R6 seg 0", 36'h4_0000_0000);
        look_chk("R6 seg 63", 36'h4_0000_FC00);
        prog(7, 36'h7_0000_0000, 16, MD_OFFSET, 0, 65);
        cfg(7, CF_ENABLE, 1);
        chk("R6 base not multiple", st_reason, RJ_BASEPE);
        prog(8, 36'h8_0000_0000, 16, MD_OFFSET, 3, 0);
        cfg(8, CF_ENABLE, 1);
        chk("R6 bad count", st_reason, RJ_COUNT);

        // R12: window smaller than segment count
        prog(9, 36'h9_0000_0000, 4, MD_EQUAL, 0, 0);
        cfg(9, CF_ENABLE, 1);
        chk("R12 too small", st_reason, RJ_SMALL);
        look_chk("R12 R1 no hit", 36'h9_0000_0003);

        // R8: writes to an enabled window are dropped
        cfg(3, CF_BASE, 36'hA_0000_0000);
        chk("R8 lock flag", st_lock_err, 1);
        look_chk("R8 base kept", 36'h1_0003_0000);
        look_chk("R8 new base not decoded", 36'hA_0000_0000);
        cfg(5, CF_SEGPE, 8'hEE, 2);
        look_chk("R8 segpe kept", 36'h3_0000_4000);

        // R9: overlaps
        prog(10, 36'h1_0000_0000, 20, MD_EQUAL, 0, 0);
        cfg(10, CF_ENABLE, 1);
        accept(10, 36'h1_0000_0000, 20, MD_EQUAL, 0, 0);
        look_chk("R9 lower beats 10", 36'h1_0005_0000);
        prog(0, 36'h1_0000_0000, 25, MD_SINGLE, 0, 8'h77);
        cfg(0, CF_ENABLE, 0);
        accept(0, 36'h1_0000_0000, 25, MD_SINGLE, 0, 8'h77);
        look_chk("R9 window 0 wins", 36'h1_0005_0000);
        chk("R9 explicit win", res_win, 0);
        cfg(0, CF_DISABLE, 0);
        m_en[0] = 0;
        look_chk("R1 disabled again", 36'h1_0005_0000);
        chk("R1 explicit win", res_win, 3);

        // R11: no strobe, no result
        @(negedge clk);
        @(negedge clk);
        chk("R11 idle valid", res_valid, 0);

        // random lookups
        for (int n = 0; n < 300; n++) begin
            int pick;
            logic [ADDR_W-1:0] a;
            logic [ADDR_W-1:0] r;
            r = {$urandom, $urandom};
            pick = $urandom_range(0, 4);
            case (pick)
                0: a = m_base[1] | (r & ~m_mask[1]);
                1: a = m_base[3] | (r & ~m_mask[3]);
                2: a = m_base[5] | (r & ~m_mask[5]);
                3: a = m_base[6] | (r & ~m_mask[6]);
                default: a = r;
            endcase
            look_chk("R2 R3 R5 R6 random", a);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule